// File: doc/BRIEF.md
# Static Seven-Segment LCD Driver, Three and a Half Digits

This block drives a directly connected (static, non-multiplexed) liquid crystal panel from a latched decimal reading. It takes three BCD digits, a thousands BCD value and a sign flag. From these it produces seven segment lines for each full digit, one shared line for the two segments of a leading "1", and a minus-sign line. It also produces a backplane square wave from the oscillator clock. Each segment line is the backplane XORed with that segment's on-state, so a lit segment sees an inverted waveform and a dark one sees an in-phase waveform. Neither case leaves a DC component across the glass.

The on-state is sampled only on backplane transitions, so segment lines never move between backplane edges. A lamp-test input overrides the reading and holds every segment line at a constant high level. The panel then shows all of its segments, a minus sign and "1888". While lamp test is active the backplane keeps running.

Top module: `lcd_static_drv`

## Requirements
- R1: The backplane `bp_o` is a 50% square wave of period PRE_DIV*BP_DIV clocks (800 by default). It toggles every 400 clocks, and the first toggle comes on the 400th rising edge after reset is released.
- R2: While `rst_ni` is low, `bp_o`, `digit_seg_o`, `lead_bc_o` and `minus_o` are all low.
- R3: Digit k (k=0 units, 1 tens, 2 hundreds) is read from `digits_i[4k+3:4k]` and drives `digit_seg_o[7k+6:7k]`, with bit 0 = a, 1 = b, 2 = c, 3 = d, 4 = e, 5 = f, 6 = g. The on-patterns are: 0 = abcdef, 1 = bc, 2 = abdeg, 3 = abcdg, 4 = bcfg, 5 = acdfg, 6 = acdefg, 7 = abc, 8 = all seven, 9 = abcdfg.
- R4: A digit code above 9 turns all seven segments of that digit off.
- R5: `lead_bc_o` is on only when `thou_i` equals 1. Every other thousands value turns it off.
- R6: `minus_o` is on only when `neg_i` is high.
- R7: Outside lamp test, each segment line equals `bp_o` when the segment is off and the inverse of `bp_o` when it is on.
- R8: Outside lamp test, segment lines change only on the clock edge where `bp_o` toggles. That edge uses the input values sampled on it, and input changes between toggles have no visible effect.
- R9: One clock after `lamp_i` rises, every segment line, the leading pair and the minus line are held constantly high. `bp_o` keeps toggling.
- R10: One clock after `lamp_i` falls, the segment lines return to R7 drive and show the reading sampled at the most recent backplane toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| digits_i | input | 12 | BCD units, tens, hundreds (4 bits each, units lowest) |
| thou_i | input | 4 | Thousands BCD value |
| neg_i | input | 1 | Reading is negative |
| lamp_i | input | 1 | Lamp test, all segments on |
| bp_o | output | 1 | Backplane square wave |
| digit_seg_o | output | 21 | Segment lines a..g per digit, units lowest |
| lead_bc_o | output | 1 | Shared b/c line of the leading "1" |
| minus_o | output | 1 | Minus-sign line |

## Verification
A fault in the divider chain shows up as a wrong backplane half-period at the first toggle, 400 clocks after reset. From then on it repeats at every toggle. A latched on-state that is wrong or updated at the wrong time appears within one backplane half-period. It shows as a segment line that is in phase where it should be inverted, or as a line that moves between toggles. A stuck lamp-test register shows within one clock, either as constant-high lines or as lines that fail to go constant. Random digit, sign and thousands values, including the blanking codes, are mixed with directed lamp-test and mid-period input changes.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

  localparam int unsigned SEG_W = 7;
  localparam int unsigned BCD_W = 4;

  typedef logic [SEG_W-1:0] seg7_t;

  localparam seg7_t SEG_OFF = '0;

  // bit 0 = a ... bit 6 = g
  function automatic seg7_t bcd_to_seg(input logic [BCD_W-1:0] bcd);
    seg7_t s;
    case (bcd)
      4'd0:    s = 7'b0111111;
      4'd1:    s = 7'b0000110;
      4'd2:    s = 7'b1011011;
      4'd3:    s = 7'b1001111;
      4'd4:    s = 7'b1100110;
      4'd5:    s = 7'b1101101;
      4'd6:    s = 7'b1111101;
      4'd7:    s = 7'b0000111;
      4'd8:    s = 7'b1111111;
      4'd9:    s = 7'b1101111;
      default: s = SEG_OFF;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/lcd_bp_gen.sv
module lcd_bp_gen #(
  parameter int unsigned PRE_DIV = 4,
  parameter int unsigned BP_DIV  = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic bp_o,
  output logic bp_edge_o
);

  localparam int unsigned HALF_TICKS = BP_DIV / 2;
  localparam int unsigned PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam int unsigned HW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;

  logic [PW-1:0] pre_cnt_q;
  logic [HW-1:0] half_cnt_q;
  logic          tick;
  logic          bp_q;

  assign tick      = (pre_cnt_q == PW'(PRE_DIV - 1));
  assign bp_edge_o = tick && (half_cnt_q == HW'(HALF_TICKS - 1));
  assign bp_o      = bp_q;

  // prescaler
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pre_cnt_q <= '0;
    else if (tick) pre_cnt_q <= '0;
    else           pre_cnt_q <= pre_cnt_q + 1'b1;
  end

  // toggle counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_cnt_q <= '0;
      bp_q       <= 1'b0;
    end else if (bp_edge_o) begin
      half_cnt_q <= '0;
      bp_q       <= ~bp_q;
    end else if (tick) begin
      half_cnt_q <= half_cnt_q + 1'b1;
    end
  end

  assert_half_cnt_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_cnt_q <= HW'(HALF_TICKS - 1));

  assert_pre_cnt_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_cnt_q <= PW'(PRE_DIV - 1));

endmodule

// File: rtl/lcd_seg_decode.sv
module lcd_seg_decode
  import lcd_drv_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 3
) (
  input  logic [NUM_DIGITS*BCD_W-1:0] digits_i,
  input  logic [BCD_W-1:0]            thou_i,
  input  logic                        neg_i,
  output logic [NUM_DIGITS*SEG_W+1:0] on_o
);

  localparam int unsigned LEAD_BIT  = NUM_DIGITS * SEG_W;
  localparam int unsigned MINUS_BIT = LEAD_BIT + 1;

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
    assign on_o[k*SEG_W +: SEG_W] = bcd_to_seg(digits_i[k*BCD_W +: BCD_W]);
  end

  assign on_o[LEAD_BIT]  = (thou_i == BCD_W'(1));
  assign on_o[MINUS_BIT] = neg_i;

endmodule

// File: rtl/lcd_seg_phase.sv
module lcd_seg_phase #(
  parameter int unsigned WIDTH = 23
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bp_i,
  input  logic             bp_edge_i,
  input  logic             lamp_i,
  input  logic [WIDTH-1:0] on_i,
  output logic [WIDTH-1:0] seg_o
);

  logic [WIDTH-1:0] on_q;
  logic             lamp_q;

  // on-state advances together with the backplane toggle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        on_q <= '0;
    else if (bp_edge_i) on_q <= on_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lamp_q <= 1'b0;
    else         lamp_q <= lamp_i;
  end

  assign seg_o = lamp_q ? {WIDTH{1'b1}} : (on_q ^ {WIDTH{bp_i}});

  assert_seg_stable_between_edges_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lamp_q && $stable(lamp_q) && $stable(bp_i)) |-> $stable(seg_o));

endmodule

// File: rtl/lcd_static_drv.sv
module lcd_static_drv
  import lcd_drv_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 3,
  parameter int unsigned PRE_DIV    = 4,
  parameter int unsigned BP_DIV     = 200
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_DIGITS*4-1:0]     digits_i,
  input  logic [3:0]                  thou_i,
  input  logic                        neg_i,
  input  logic                        lamp_i,
  output logic                        bp_o,
  output logic [NUM_DIGITS*7-1:0]     digit_seg_o,
  output logic                        lead_bc_o,
  output logic                        minus_o
);

  localparam int unsigned ALL_W     = NUM_DIGITS * SEG_W + 2;
  localparam int unsigned HALF_CLKS = PRE_DIV * BP_DIV / 2;
  localparam int unsigned CW        = $clog2(HALF_CLKS + 1) + 1;

  logic             bp;
  logic             bp_edge;
  logic [ALL_W-1:0] on_state;
  logic [ALL_W-1:0] seg_all;

  lcd_bp_gen #(
    .PRE_DIV (PRE_DIV),
    .BP_DIV  (BP_DIV)
  ) i_bp_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bp_o      (bp),
    .bp_edge_o (bp_edge)
  );

  lcd_seg_decode #(
    .NUM_DIGITS (NUM_DIGITS)
  ) i_decode (
    .digits_i (digits_i),
    .thou_i   (thou_i),
    .neg_i    (neg_i),
    .on_o     (on_state)
  );

  lcd_seg_phase #(
    .WIDTH (ALL_W)
  ) i_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bp_i      (bp),
    .bp_edge_i (bp_edge),
    .lamp_i    (lamp_i),
    .on_i      (on_state),
    .seg_o     (seg_all)
  );

  assign bp_o        = bp;
  assign digit_seg_o = seg_all[NUM_DIGITS*SEG_W-1:0];
  assign lead_bc_o   = seg_all[NUM_DIGITS*SEG_W];
  assign minus_o     = seg_all[NUM_DIGITS*SEG_W+1];

  // half-period watch counter, independent of the divider
  logic [CW-1:0] chk_cnt_q;
  logic          chk_bp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_cnt_q <= '0;
      chk_bp_q  <= 1'b0;
    end else begin
      chk_bp_q  <= bp_o;
      chk_cnt_q <= (bp_o != chk_bp_q) ? CW'(1) : chk_cnt_q + 1'b1;
    end
  end

  assert_bp_half_period_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bp_o != $past(bp_o)) |-> ($past(chk_cnt_q) == CW'(HALF_CLKS - 1)));

  assert_bp_no_missing_toggle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_cnt_q <= CW'(HALF_CLKS));

  assert_minus_phase_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bp_o != $past(bp_o)) && !$past(lamp_i)) |-> ((minus_o ^ bp_o) == $past(neg_i)));

  assert_lead_phase_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bp_o != $past(bp_o)) && !$past(lamp_i)) |-> ((lead_bc_o ^ bp_o) == ($past(thou_i) == 4'd1)));

  assert_lamp_all_on_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lamp_i) |-> ((&digit_seg_o) && lead_bc_o && minus_o));

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_blank_chk
    assert_blank_code_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((bp_o != $past(bp_o)) && !$past(lamp_i) && ($past(digits_i[k*4 +: 4]) > 4'd9))
      |-> ((digit_seg_o[k*7 +: 7] ^ {7{bp_o}}) == 7'd0));
  end

endmodule

// File: tb/test_lcd_static_drv.sv
module test_lcd_static_drv;

  localparam int HALF = 400;
  localparam int WD_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] digits = '0;
  logic [3:0]  thou = '0;
  logic        neg = 1'b0;
  logic        lamp = 1'b0;
  logic        bp;
  logic [20:0] dseg;
  logic        lead;
  logic        minus;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lcd_static_drv i_lcd_static_drv (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .digits_i    (digits),
    .thou_i      (thou),
    .neg_i       (neg),
    .lamp_i      (lamp),
    .bp_o        (bp),
    .digit_seg_o (dseg),
    .lead_bc_o   (lead),
    .minus_o     (minus)
  );

  function automatic logic [6:0] ref_seg(input logic [3:0] b);
    case (b)
      4'd0: return 7'b0111111;
      4'd1: return 7'b0000110;
      4'd2: return 7'b1011011;
      4'd3: return 7'b1001111;
      4'd4: return 7'b1100110;
      4'd5: return 7'b1101101;
      4'd6: return 7'b1111101;
      4'd7: return 7'b0000111;
      4'd8: return 7'b1111111;
      4'd9: return 7'b1101111;
      default: return 7'b0000000;
    endcase
  endfunction

  function automatic logic [22:0] ref_on(input logic [11:0] d, input logic [3:0] t, input logic n);
    return {n, (t == 4'd1), ref_seg(d[11:8]), ref_seg(d[7:4]), ref_seg(d[3:0])};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // waits until bp changes; returns clocks waited
  task automatic wait_toggle(output int n);
    logic prev;
    prev = bp;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (bp == prev && n < 2000);
  endtask

  task automatic apply(input logic [11:0] d, input logic [3:0] t, input logic n);
    digits = d;
    thou   = t;
    neg    = n;
  endtask

  // check all lines against a latched reading
  task automatic chk_shown(input string req, input logic [22:0] on);
    chk(req, {minus, lead, dseg}, on ^ {23{bp}});
  endtask

  initial begin : wd
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int n;
    logic [22:0] last_on;
    void'($urandom(32'd2024));

    // R2 reset state
    repeat (5) @(negedge clk);
    chk("R2 reset lines", {bp, minus, lead, dseg}, 24'd0);
    apply(12'h987, 4'd1, 1'b1);
    repeat (3) @(negedge clk);
    chk("R2 reset holds", {bp, minus, lead, dseg}, 24'd0);
    apply(12'h000, 4'd0, 1'b0);
    rst_n = 1'b1;

    // R1 first toggle and period
    n = 0;
    do begin @(negedge clk); n++; end while (!bp && n < 2000);
    chk("R1 first toggle", n, HALF);
    wait_toggle(n);
    chk("R1 high half", n, HALF);
    wait_toggle(n);
    chk("R1 low half", n, HALF);

    // R3 every digit code on each position, R7 phase
    for (int v = 0; v < 10; v++) begin
      apply({4'(v), 4'(9 - v), 4'(v)}, 4'd0, 1'b0);
      wait_toggle(n);
      chk($sformatf("R3 R7 digit %0d", v), {minus, lead, dseg}, ref_on(digits, thou, neg) ^ {23{bp}});
    end

    // R4 blanking codes
    for (int v = 10; v < 16; v++) begin
      apply({4'(v), 4'd8, 4'(v)}, 4'd0, 1'b0);
      wait_toggle(n);
      chk($sformatf("R4 blank code %0d", v), dseg ^ {21{bp}}, {7'd0, 7'b1111111, 7'd0});
    end

    // R5 thousands values, R6 sign
    for (int t = 0; t < 16; t += 3) begin
      apply(12'h123, 4'(t), t[0]);
      wait_toggle(n);
      chk($sformatf("R5 lead thou=%0d", t), lead ^ bp, (t == 1));
      chk($sformatf("R6 minus neg=%0d", t[0]), minus ^ bp, t[0]);
    end
    apply(12'h123, 4'd1, 1'b0);
    wait_toggle(n);
    chk("R5 lead thou=1", lead ^ bp, 1'b1);

    // random readings, R3 R5 R6 R7
    for (int i = 0; i < 40; i++) begin
      apply(12'($urandom), 4'($urandom % 3), 1'($urandom));
      wait_toggle(n);
      chk("R3 R5 R6 R7 random", {minus, lead, dseg}, ref_on(digits, thou, neg) ^ {23{bp}});
    end

    // R8 mid-period change has no effect until next toggle
    apply(12'h456, 4'd1, 1'b0);
    wait_toggle(n);
    last_on = ref_on(digits, thou, neg);
    apply(12'h801, 4'd0, 1'b1);
    begin
      int bad = 0;
      for (int c = 0; c < HALF - 10; c++) begin
        @(negedge clk);
        if ({minus, lead, dseg} !== (last_on ^ {23{bp}})) bad++;
      end
      chk("R8 held between toggles", bad, 0);
    end
    wait_toggle(n);
    chk_shown("R8 new reading at toggle", ref_on(12'h801, 4'd0, 1'b1));
    last_on = ref_on(12'h801, 4'd0, 1'b1);

    // R9 lamp test
    @(negedge clk);
    lamp = 1'b1;
    @(negedge clk);
    chk("R9 lamp one clock", {minus, lead, dseg}, {23{1'b1}});
    begin
      int bad = 0;
      int tog = 0;
      logic pb;
      pb = bp;
      for (int c = 0; c < 2 * HALF + 20; c++) begin
        @(negedge clk);
        if ({minus, lead, dseg} !== {23{1'b1}}) bad++;
        if (bp != pb) tog++;
        pb = bp;
      end
      chk("R9 lamp constant", bad, 0);
      chk("R9 bp runs", tog, 2);
    end

    // R10 release shows the reading latched at the last toggle
    apply(12'h555, 4'd0, 1'b0);
    wait_toggle(n);
    apply(12'h000, 4'd1, 1'b1);
    repeat (3) @(negedge clk);
    lamp = 1'b0;
    @(negedge clk);
    chk_shown("R10 release latched", ref_on(12'h555, 4'd0, 1'b0));
    wait_toggle(n);
    chk_shown("R10 next toggle", ref_on(12'h000, 4'd1, 1'b1));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule